// File: doc/BRIEF.md
# USB Device Suspend and Resume Controller

This block watches a device-side USB link for inactivity and moves the device into a low-power suspend state after a fixed quiet interval. While suspended it holds the PHY in its suspend mode. It leaves suspend in two ways. The first is when resume signalling from the host is detected. The second is when software raises its resume request, in which case the block drives resume signalling onto the bus for as long as the request stays set. Suspend entry and host-initiated resume each produce a one-cycle interrupt pulse, and each pulse is gated by its own enable.

All intervals are derived from one parameter, `CYC_PER_MS`, which gives the number of clock cycles in one millisecond. The quiet interval is 3 ms. Software is expected to hold the resume request for between 10 ms and 15 ms. The block does not shorten or stretch the request. It only flags a hold time that falls outside that window.

Top module: `usb_susp_ctl`

## Requirements
- R1: `phy_suspend` rises at the clock edge that samples the 3·CYC_PER_MS-th consecutive cycle in which `bus_active`, `resume_detect` and `sw_resume` are all low.
- R2: A cycle in which any of `bus_active`, `resume_detect` or `sw_resume` is high, while awake, restarts the quiet count from zero. With a limit of 12 cycles, 11 quiet cycles followed by activity do not cause suspend.
- R3: `irq_suspend` is a one-cycle pulse that is high in the first cycle `phy_suspend` is high, and only if `ie_suspend` was high at that edge. It is never high together with `irq_resume`.
- R4: While suspended, the quiet count is held. `bus_active` alone does not end suspend: `phy_suspend` stays high until `resume_detect` or `sw_resume` is sampled high.
- R5: `resume_detect` sampled high while suspended clears `phy_suspend` at that edge. `irq_resume` pulses for one cycle at the same time if `ie_resume` is high. An exit caused only by `sw_resume` gives no `irq_resume`.
- R6: `drive_resume` equals `sw_resume` delayed by one clock cycle.
- R7: `resume_timing_err` becomes 1 when `sw_resume` falls after being sampled high on fewer than 10·CYC_PER_MS edges.
- R8: `resume_timing_err` becomes 1 at the edge that samples `sw_resume` high for the (15·CYC_PER_MS+1)-th consecutive time.
- R9: `resume_timing_err` is sticky. It clears only at the edge where a new rising `sw_resume` is sampled. A hold of 10·CYC_PER_MS to 15·CYC_PER_MS cycles leaves it at 0.
- R10: During and after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_active | input | 1 | Bus activity seen this cycle |
| resume_detect | input | 1 | Resume signalling from the host detected |
| sw_resume | input | 1 | Software resume request, held by software |
| ie_suspend | input | 1 | Suspend interrupt enable |
| ie_resume | input | 1 | Resume interrupt enable |
| phy_suspend | output | 1 | PHY suspend control, high while suspended |
| drive_resume | output | 1 | Drive resume signalling onto the bus |
| irq_suspend | output | 1 | One-cycle suspend-entry interrupt |
| irq_resume | output | 1 | One-cycle host-resume interrupt |
| resume_timing_err | output | 1 | Sticky flag for a resume request held outside 10 to 15 ms |

## Verification
The bench targets the quiet-count boundary, one cycle short of the limit and exactly at it. A counter that is off by one would suspend too early or too late, and one that fails to restart on activity would suspend during traffic. It holds the resume request for exactly the shortest and longest legal lengths and one cycle outside each. A window check that is off by one would raise or miss the error flag there. It also separates a host-initiated wake from a software wake, so that a design which raises the resume interrupt for both is caught. Finally, it checks that bus activity alone cannot end suspend.

// File: rtl/usb_susp_ctl.sv
module usb_susp_ctl #(
  parameter int CYC_PER_MS = 60000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_active,
  input  logic resume_detect,
  input  logic sw_resume,
  input  logic ie_suspend,
  input  logic ie_resume,
  output logic phy_suspend,
  output logic drive_resume,
  output logic irq_suspend,
  output logic irq_resume,
  output logic resume_timing_err
);
  localparam int IDLE_LIM = 3 * CYC_PER_MS;
  localparam int HOLD_MIN = 10 * CYC_PER_MS;
  localparam int HOLD_MAX = 15 * CYC_PER_MS;
  localparam int IW = $clog2(IDLE_LIM + 1);
  localparam int HW = $clog2(HOLD_MAX + 2);

  logic [IW-1:0] idle_q;
  logic [HW-1:0] hold_q;
  logic          busy, wake, at_lim, req_rise, req_fall;

  assign busy     = bus_active | resume_detect | sw_resume;
  assign wake     = resume_detect | sw_resume;
  assign at_lim   = (idle_q == IW'(IDLE_LIM - 1));
  assign req_rise = sw_resume & ~drive_resume;
  assign req_fall = ~sw_resume & drive_resume;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phy_suspend <= 1'b0;
      idle_q      <= '0;
      irq_suspend <= 1'b0;
      irq_resume  <= 1'b0;
    end else begin
      irq_suspend <= 1'b0;
      irq_resume  <= 1'b0;
      if (phy_suspend) begin
        if (wake) begin
          phy_suspend <= 1'b0;
          irq_resume  <= resume_detect & ie_resume;
        end
      end else if (busy) begin
        idle_q <= '0;
      end else if (at_lim) begin
        phy_suspend <= 1'b1;
        idle_q      <= '0;
        irq_suspend <= ie_suspend;
      end else begin
        idle_q <= idle_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drive_resume      <= 1'b0;
      hold_q            <= '0;
      resume_timing_err <= 1'b0;
    end else begin
      drive_resume <= sw_resume;
      if (req_rise) begin
        hold_q            <= HW'(1);
        resume_timing_err <= 1'b0;
      end else if (sw_resume) begin
        if (hold_q == HW'(HOLD_MAX)) resume_timing_err <= 1'b1;
        if (hold_q <= HW'(HOLD_MAX)) hold_q <= hold_q + 1'b1;
      end else if (req_fall) begin
        if (hold_q < HW'(HOLD_MIN)) resume_timing_err <= 1'b1;
        hold_q <= '0;
      end
    end
  end
endmodule

// File: rtl/usb_susp_ctl_chk.sv
module usb_susp_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic resume_detect,
  input logic sw_resume,
  input logic ie_suspend,
  input logic ie_resume,
  input logic phy_suspend,
  input logic drive_resume,
  input logic irq_suspend,
  input logic irq_resume,
  input logic resume_timing_err
);
  AST_SUSP_IRQ_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_suspend |-> (phy_suspend && !$past(phy_suspend))); // R3
  AST_SUSP_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_suspend |-> $past(ie_suspend)); // R3
  AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_suspend, irq_resume})); // R3
  AST_STAY_SUSPENDED: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_suspend && !resume_detect && !sw_resume) |=> phy_suspend); // R4
  AST_RESUME_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_resume |-> (!phy_suspend && $past(phy_suspend) && $past(resume_detect) && $past(ie_resume))); // R5
  AST_DRIVE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_resume |=> drive_resume); // R6
  AST_DRIVE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_resume |=> !drive_resume); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_timing_err && !(sw_resume && !drive_resume)) |=> resume_timing_err); // R9
endmodule

bind usb_susp_ctl usb_susp_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .resume_detect(resume_detect), .sw_resume(sw_resume),
  .ie_suspend(ie_suspend), .ie_resume(ie_resume), .phy_suspend(phy_suspend),
  .drive_resume(drive_resume), .irq_suspend(irq_suspend), .irq_resume(irq_resume),
  .resume_timing_err(resume_timing_err)
);

// File: tb/sim_usb_susp_ctl.sv
`timescale 1ns/1ps
module sim_usb_susp_ctl;
  localparam int CPM  = 4;
  localparam int IDLE = 3 * CPM;
  localparam int HMIN = 10 * CPM;
  localparam int HMAX = 15 * CPM;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_active = 1'b0, resume_detect = 1'b0, sw_resume = 1'b0;
  logic ie_suspend = 1'b0, ie_resume = 1'b0;
  logic phy_suspend, drive_resume, irq_suspend, irq_resume, resume_timing_err;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit e_susp = 0, e_isus = 0, e_ires = 0, e_drv = 0, e_err = 0;
  int idle = 0, hold = 0;

  always #10 clk = ~clk;

  usb_susp_ctl #(.CYC_PER_MS(CPM)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_active(bus_active), .resume_detect(resume_detect),
    .sw_resume(sw_resume), .ie_suspend(ie_suspend), .ie_resume(ie_resume),
    .phy_suspend(phy_suspend), .drive_resume(drive_resume), .irq_suspend(irq_suspend),
    .irq_resume(irq_resume), .resume_timing_err(resume_timing_err)
  );

  function automatic bit quiet_hits_limit(int count);
    return count == IDLE - 1;
  endfunction

  function automatic bit hold_outside(int n);
    return (n < HMIN) || (n > HMAX);
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      e_susp = 0; e_isus = 0; e_ires = 0; e_drv = 0; e_err = 0; idle = 0; hold = 0;
    end else begin
      e_isus = 0; e_ires = 0;
      if (e_susp) begin
        if (resume_detect || sw_resume) begin
          e_susp = 0;
          e_ires = resume_detect && ie_resume;
        end
      end else if (bus_active || resume_detect || sw_resume) idle = 0;
      else if (quiet_hits_limit(idle)) begin
        e_susp = 1; idle = 0; e_isus = ie_suspend;
      end else idle++;
      if (sw_resume) begin
        if (!e_drv) begin e_err = 0; hold = 1; end
        else begin
          hold++;
          if (hold > HMAX) e_err = 1;
        end
      end else if (e_drv) begin
        if (hold_outside(hold)) e_err = 1;
        hold = 0;
      end
      e_drv = sw_resume;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R1/R2/R4/R5 phy_suspend", phy_suspend, e_susp);
    chk("R3 irq_suspend", irq_suspend, e_isus);
    chk("R5 irq_resume", irq_resume, e_ires);
    chk("R6 drive_resume", drive_resume, e_drv);
    chk("R7/R8/R9 resume_timing_err", resume_timing_err, e_err);
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet(int n);
    bus_active = 0; resume_detect = 0; sw_resume = 0;
    step(n);
  endtask

  task automatic hold_req(int n);
    sw_resume = 1; step(n); sw_resume = 0; step(2);
  endtask

  initial begin
    int unused;
    unused = $urandom(20240611);
    step(3);
    chk("R10 phy_suspend reset", phy_suspend, 1'b0);
    chk("R10 drive_resume reset", drive_resume, 1'b0);
    chk("R10 irq reset", irq_suspend | irq_resume, 1'b0);
    chk("R10 err reset", resume_timing_err, 1'b0);
    rst_n = 1;
    ie_suspend = 1; ie_resume = 1;
    // R2: one short of the limit, then activity
    quiet(IDLE - 1); bus_active = 1; step(1);
    quiet(IDLE - 1);
    chk("R2 no early suspend", phy_suspend, 1'b0);
    step(1);
    chk("R1 suspend at limit", phy_suspend, 1'b1);
    chk("R3 suspend irq", irq_suspend, 1'b1);
    // R4: activity alone does not wake
    bus_active = 1; step(5); bus_active = 0;
    chk("R4 stays suspended", phy_suspend, 1'b1);
    resume_detect = 1; step(1); resume_detect = 0;
    chk("R5 host wake", phy_suspend, 1'b0);
    chk("R5 resume irq", irq_resume, 1'b1);
    quiet(IDLE + 2);
    sw_resume = 1; step(1);
    chk("R5 sw wake no irq", irq_resume, 1'b0);
    chk("R6 drive", drive_resume, 1'b1);
    step(HMIN - 1); sw_resume = 0; step(2);
    chk("R9 min legal hold", resume_timing_err, 1'b0);
    hold_req(HMAX);
    chk("R9 max legal hold", resume_timing_err, 1'b0);
    hold_req(HMIN - 1);
    chk("R7 short hold", resume_timing_err, 1'b1);
    quiet(4);
    chk("R9 sticky", resume_timing_err, 1'b1);
    hold_req(HMAX + 1);
    chk("R8 long hold", resume_timing_err, 1'b1);
    ie_suspend = 0; quiet(IDLE + 1);
    chk("R3 gated irq", irq_suspend, 1'b0);
    // random phase
    for (int i = 0; i < 300; i++) begin
      int k;
      k = $urandom_range(0, 9);
      ie_suspend = $urandom_range(0, 1);
      ie_resume  = $urandom_range(0, 1);
      if (k < 2) hold_req($urandom_range(HMIN - 10, HMAX + 10));
      else if (k < 4) begin resume_detect = 1; step(1); resume_detect = 0; end
      else begin
        for (int j = 0; j < 20; j++) begin
          bus_active = ($urandom_range(0, 15) == 0);
          step(1);
        end
        bus_active = 0;
      end
    end
    step(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule